// File: doc/BRIEF.md
# Front-End Power Mode and Wake Controller

This block turns two mode pins, a suspend request and a power-down request, into one of four operating modes for a line front end. The mode gates the master clock output and drives the power-down controls of the analog and digital sections. In the low-power listening mode it can arm an external tone detector. It forwards the tone choice to that detector. A hit reported by the detector sets a wake flag. The flag then holds until the device is back in full operation.

After an asynchronous reset, the block keeps the clock output gated and both sections powered down. It waits until the oscillator reports ready and then counts a programmed number of master-clock cycles. The two mode pins are synchronized before decode, so the logic sees a mode change two edges after the pins move. The analog detector itself lies outside this block. The block only enables it, tells it which tone to listen for, and receives its hit pulse.

Top module: `afe_power_ctrl`

## Requirements
- R1: While `rst_n` is low, and with no clock edge needed, the outputs take these values: `clk_out_en`=0, `ana_pd`=1, `dig_pd`=1, `tone_det_en`=0 and `wake_flag`=0.
- R2: After reset, `clk_out_en` stays 0 and both power-down outputs stay 1 until SETTLE_CYCLES rising edges have occurred with `osc_ready` high. Edges with `osc_ready` low are not counted, and the counting resumes when it returns high. The modes below apply from the edge that completes the count.
- R3: A change on `suspend_in` or `pwd_in` leaves the outputs unchanged after the first rising edge. It shows on the outputs after the second rising edge.
- R4: Mode {suspend,pwd}=00 (full operation) gives `clk_out_en`=1, `ana_pd`=0, `dig_pd`=0 and `tone_det_en`=0.
- R5: Mode 01 (configuration) gives `clk_out_en`=1, `ana_pd`=1, `dig_pd`=0 and `tone_det_en`=0.
- R6: Mode 10 (listening) gives `clk_out_en`=0, `ana_pd`=1 and `dig_pd`=1. In this mode `tone_det_en` equals `sleep_en`.
- R7: Mode 11 (standby) gives `clk_out_en`=0, `ana_pd`=1, `dig_pd`=1 and `tone_det_en`=0.
- R8: `tone_sel_out` follows `tone_sel`. The value 0 selects the standard-band tone (index 40) and the value 1 selects the tone used over an ISDN line (index 72).
- R9: A `tone_hit` sampled high at a rising edge while `tone_det_en` is 1 sets `wake_flag` after that edge. A `tone_hit` in any other case leaves `wake_flag` unchanged.
- R10: Once set, `wake_flag` holds through the configuration, listening and standby modes. It clears on the rising edge after full-operation mode takes effect, which is the third edge after the pins change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock from the crystal oscillator |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_ready | input | 1 | Oscillator has started and is stable |
| suspend_in | input | 1 | Suspend request pin (asynchronous) |
| pwd_in | input | 1 | Power-down request pin (asynchronous) |
| sleep_en | input | 1 | Register bit allowing the tone detector to run while listening |
| tone_sel | input | 1 | Register bit choosing the wake tone |
| tone_hit | input | 1 | Hit pulse from the analog tone comparator |
| clk_out_en | output | 1 | Enable for the master and word clock outputs |
| ana_pd | output | 1 | Analog section power-down, 1 = off |
| dig_pd | output | 1 | Digital section power-down, 1 = off |
| tone_det_en | output | 1 | Tone detector enable |
| tone_sel_out | output | 1 | Tone choice passed to the detector |
| wake_flag | output | 1 | Latched wake request |

## Verification
The bench builds the block with SETTLE_CYCLES=5 in place of the 2 ms default. With that value, the exact edge where the clocks start can be reached in a few cycles. A pause of `osc_ready` in the middle of the count can be shown to delay the start without restarting the count. With the short settle count, every pair of old and new modes can also be swept, for all values of the sleep and tone bits, and each change checked both one and two edges after the pins move. The wake flag is then driven through set, hold, ignored-hit and clear sequences, and through an asynchronous reset while the flag is set.

// File: rtl/afe_pwr_pkg.sv
package afe_pwr_pkg;

  // Mode code is {suspend, pwd}.
  typedef enum logic [1:0] {
    MODE_ACTIVE  = 2'b00,
    MODE_CONFIG  = 2'b01,
    MODE_LISTEN  = 2'b10,
    MODE_STANDBY = 2'b11
  } pmode_t;

  function automatic pmode_t decode_mode(input logic susp, input logic pwd);
    pmode_t m;
    case ({susp, pwd})
      2'b00:   m = MODE_ACTIVE;
      2'b01:   m = MODE_CONFIG;
      2'b10:   m = MODE_LISTEN;
      default: m = MODE_STANDBY;
    endcase
    return m;
  endfunction

  function automatic logic mode_clk_on(input pmode_t m);
    return (m == MODE_ACTIVE) || (m == MODE_CONFIG);
  endfunction

  function automatic logic mode_ana_off(input pmode_t m);
    return m != MODE_ACTIVE;
  endfunction

  function automatic logic mode_dig_off(input pmode_t m);
    return (m == MODE_LISTEN) || (m == MODE_STANDBY);
  endfunction

  function automatic logic mode_tone_ok(input pmode_t m);
    return m == MODE_LISTEN;
  endfunction

endpackage

// File: rtl/afe_pwr_sync.sv
module afe_pwr_sync #(
  parameter int           WIDTH   = 2,
  parameter int           STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= RST_VAL;
          else        stg[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= RST_VAL;
          else        stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/afe_pwr_settle.sv
module afe_pwr_settle #(
  parameter int CYCLES = 70656
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_ready,
  output logic settled
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          count_en;

  assign count_en = osc_ready && !settled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      settled <= 1'b0;
    end else if (count_en) begin
      if (cnt == LAST) settled <= 1'b1;
      else             cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/afe_pwr_wake.sv
module afe_pwr_wake (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic hit,
  input  logic clear,
  output logic set_evt,
  output logic flag
);
  assign set_evt = armed && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (clear)   flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
  end
endmodule

// File: rtl/afe_power_ctrl.sv
module afe_power_ctrl
  import afe_pwr_pkg::*;
#(
  parameter int SETTLE_CYCLES = 70656,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_ready,
  input  logic suspend_in,
  input  logic pwd_in,
  input  logic sleep_en,
  input  logic tone_sel,
  input  logic tone_hit,
  output logic clk_out_en,
  output logic ana_pd,
  output logic dig_pd,
  output logic tone_det_en,
  output logic tone_sel_out,
  output logic wake_flag
);
  localparam int PIN_W = 2;

  logic [PIN_W-1:0] pins_s;
  logic             settled;
  pmode_t           mode_q;
  logic             wake_set_evt;
  logic             wake_clr_evt;

  afe_pwr_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b11)
  ) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({suspend_in, pwd_in}),
    .q    (pins_s)
  );

  afe_pwr_settle #(
    .CYCLES(SETTLE_CYCLES)
  ) i_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_ready(osc_ready),
    .settled  (settled)
  );

  assign mode_q = decode_mode(pins_s[1], pins_s[0]);

  assign clk_out_en   = settled && mode_clk_on(mode_q);
  assign ana_pd       = !settled || mode_ana_off(mode_q);
  assign dig_pd       = !settled || mode_dig_off(mode_q);
  assign tone_det_en  = settled && mode_tone_ok(mode_q) && sleep_en;
  assign tone_sel_out = tone_sel;

  assign wake_clr_evt = (mode_q == MODE_ACTIVE);

  afe_pwr_wake i_wake (
    .clk    (clk),
    .rst_n  (rst_n),
    .armed  (tone_det_en),
    .hit    (tone_hit),
    .clear  (wake_clr_evt),
    .set_evt(wake_set_evt),
    .flag   (wake_flag)
  );
endmodule

// File: rtl/afe_power_ctrl_chk.sv
module afe_power_ctrl_chk
  import afe_pwr_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   suspend_in,
  input logic   tone_hit,
  input logic   clk_out_en,
  input logic   ana_pd,
  input logic   dig_pd,
  input logic   tone_det_en,
  input logic   wake_flag,
  input logic   settled,
  input pmode_t mode_q
);
  AST_CLK_FOLLOWS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    clk_out_en |-> !$past(suspend_in, 2)); // R3
  AST_SETTLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !settled |-> (!clk_out_en && ana_pd && dig_pd && !tone_det_en)); // R2
  AST_SETTLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    settled |=> settled); // R2
  AST_DIG_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    !dig_pd |-> clk_out_en); // R5
  AST_TONE_ONLY_LISTEN: assert property (@(posedge clk) disable iff (!rst_n)
    tone_det_en |-> (ana_pd && dig_pd && !clk_out_en)); // R6
  AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> $past(tone_det_en && tone_hit)); // R9
  AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_flag && mode_q != MODE_ACTIVE) |=> wake_flag); // R10
  AST_WAKE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ACTIVE) |=> !wake_flag); // R10
  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |-> (!clk_out_en && ana_pd && dig_pd && !wake_flag)); // R1
endmodule

bind afe_power_ctrl afe_power_ctrl_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .suspend_in (suspend_in),
  .tone_hit   (tone_hit),
  .clk_out_en (clk_out_en),
  .ana_pd     (ana_pd),
  .dig_pd     (dig_pd),
  .tone_det_en(tone_det_en),
  .wake_flag  (wake_flag),
  .settled    (settled),
  .mode_q     (mode_q)
);

// File: tb/test_afe_power_ctrl.sv
module test_afe_power_ctrl;
  localparam int SETTLE = 5;

  logic clk = 1'b0;
  logic rst_n, osc_ready, suspend_in, pwd_in, sleep_en, tone_sel, tone_hit;
  logic clk_out_en, ana_pd, dig_pd, tone_det_en, tone_sel_out, wake_flag;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  afe_power_ctrl #(.SETTLE_CYCLES(SETTLE)) i_afe_power_ctrl (
    .clk(clk), .rst_n(rst_n), .osc_ready(osc_ready),
    .suspend_in(suspend_in), .pwd_in(pwd_in), .sleep_en(sleep_en),
    .tone_sel(tone_sel), .tone_hit(tone_hit), .clk_out_en(clk_out_en),
    .ana_pd(ana_pd), .dig_pd(dig_pd), .tone_det_en(tone_det_en),
    .tone_sel_out(tone_sel_out), .wake_flag(wake_flag)
  );

  // {clk_out_en, ana_pd, dig_pd, tone_det_en} for mode code {susp,pwd}
  function automatic logic [3:0] expect4(input logic [1:0] m, input logic sl);
    logic s, p;
    s = m[1];
    p = m[0];
    return {~s, s | p, s, s & ~p & sl};
  endfunction

  function automatic logic [3:0] outs4();
    return {clk_out_en, ana_pd, dig_pd, tone_det_en};
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #5;
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    suspend_in = m[1];
    pwd_in     = m[0];
  endtask

  task automatic pulse_hit();
    tone_hit = 1'b1;
    step(1);
    tone_hit = 1'b0;
  endtask

  initial begin
    logic [1:0] prev_m;
    rst_n = 1'b0; osc_ready = 1'b0; suspend_in = 1'b1; pwd_in = 1'b1;
    sleep_en = 1'b0; tone_sel = 1'b0; tone_hit = 1'b0;
    #50;
    check("R1 reset outputs", {outs4()}, 4'b0110);
    check("R1 reset wake", {3'b0, wake_flag}, 4'b0);
    step(1);
    rst_n = 1'b1;
    set_mode(2'b00);
    step(3);
    check("R2 no osc, clocks off", outs4(), 4'b0110);
    // settle: 2 qualifying edges, pause 2, then 3 more
    osc_ready = 1'b1; step(2);
    osc_ready = 1'b0; step(2);
    check("R2 paused count", outs4(), 4'b0110);
    osc_ready = 1'b1; step(2);
    check("R2 one edge short", outs4(), 4'b0110);
    step(1);
    check("R2 settled active", outs4(), expect4(2'b00, 1'b0));
    check("R4 active", outs4(), 4'b1000);

    // sweep every mode transition and register bit combination
    prev_m = 2'b00;
    for (int r = 0; r < 2; r++) begin
      for (int m = 0; m < 4; m++) begin
        for (int sl = 0; sl < 2; sl++) begin
          for (int ts = 0; ts < 2; ts++) begin
            set_mode(m[1:0]);
            sleep_en = sl[0];
            tone_sel = ts[0];
            #1;
            check("R8 tone select", {3'b0, tone_sel_out}, {3'b0, ts[0]});
            step(1);
            check("R3 first edge unchanged", outs4(), expect4(prev_m, sl[0]));
            step(1);
            case (m)
              0: check("R4 active mode", outs4(), expect4(2'b00, sl[0]));
              1: check("R5 config mode", outs4(), expect4(2'b01, sl[0]));
              2: check("R6 listen mode", outs4(), expect4(2'b10, sl[0]));
              default: check("R7 standby mode", outs4(), expect4(2'b11, sl[0]));
            endcase
            check("R9 no hit no wake", {3'b0, wake_flag}, 4'b0);
            prev_m = m[1:0];
          end
        end
      end
    end

    // ignored hits
    set_mode(2'b10); sleep_en = 1'b0; step(2);
    pulse_hit();
    check("R9 hit ignored when sleep bit 0", {3'b0, wake_flag}, 4'b0);
    set_mode(2'b01); step(2);
    pulse_hit();
    check("R9 hit ignored in config", {3'b0, wake_flag}, 4'b0);
    set_mode(2'b11); step(2);
    pulse_hit();
    check("R9 hit ignored in standby", {3'b0, wake_flag}, 4'b0);
    set_mode(2'b00); step(2);
    pulse_hit();
    check("R9 hit ignored in active", {3'b0, wake_flag}, 4'b0);

    // armed hit, hold, clear
    set_mode(2'b10); sleep_en = 1'b1; step(2);
    check("R6 detector armed", outs4(), 4'b0111);
    pulse_hit();
    check("R9 wake set", {3'b0, wake_flag}, 4'b1);
    set_mode(2'b01); step(4);
    check("R10 hold in config", {3'b0, wake_flag}, 4'b1);
    set_mode(2'b11); step(3);
    check("R10 hold in standby", {3'b0, wake_flag}, 4'b1);
    set_mode(2'b00); step(2);
    check("R10 still set as active begins", {3'b0, wake_flag}, 4'b1);
    step(1);
    check("R10 cleared in active", {3'b0, wake_flag}, 4'b0);

    // asynchronous reset while woken
    set_mode(2'b10); step(2);
    pulse_hit();
    check("R9 wake set again", {3'b0, wake_flag}, 4'b1);
    rst_n = 1'b0;
    #1;
    check("R1 async reset outputs", outs4(), 4'b0110);
    check("R1 async reset wake", {3'b0, wake_flag}, 4'b0);
    step(2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule